// File: doc/BRIEF.md
# Multi-Waveform Audio Oscillator

This block is a direct digital synthesis oscillator for audio-rate sound generation inside a fast system clock domain. A 32-bit main phase accumulator and a second low-frequency accumulator step forward only when a one-cycle sample strobe arrives, which is typically at 48 kHz within a 100 MHz clock. Each tuning word is the phase increment per sample, so f_out = tune × 48000 / 2^32. The phase wraps modulo 2^32 and is never cleared by a change of tuning.

A three-bit shape select picks what the main phase produces. The choices are a sine from a quarter-wave table, a rising ramp, a falling ramp, a square wave, or a pulse-width-modulated square. For the PWM shape, the sine of the low-frequency phase moves the switching threshold, which keeps the duty cycle between 10% and 90%. Sweeping that accumulator changes the timbre. A processor drives the two tuning words and the select as plain held values. Each strobe samples them, and the new output sample appears with a one-cycle valid pulse two clocks after the strobe.

Top module: `wavesynth_osc`

## Requirements
- R1: While `rst_n` is low and after its release, `wave_out` is 0 and `wave_vld` is 0 until the first strobe, and both phases start at 0, so the first sample after reset uses main phase = `tune_main`.
- R2: At each clock with `smp_tick` high, the main phase becomes (phase + `tune_main`) mod 2^32 and the LFO phase becomes (phase + `tune_lfo`) mod 2^32. The values used are those present in that strobe cycle. Changing a tuning word never resets a phase, and between strobes neither phase moves.
- R3: `wave_vld` is high for exactly one cycle, two clocks after a strobe. `wave_out` changes only together with that pulse and holds its value otherwise.
- R4: Select code 0 (sine). Let p be the main phase, q = p[31:30], and i = p[29:20], with i replaced by 1023−i when q[0]=1. Let a=2i+1. Then m = floor(32767·16·a·(4096−a) / (5·4096² − 4·a·(4096−a))), and the output is m when q[1]=0 and −m when q[1]=1.
- R5: Select code 1 (rising ramp). The output is the signed 16-bit value p[31:16] − 32768, so it rises from −32768 to 32767 over one period.
- R6: Select code 2 (falling ramp). The output is the bitwise inverse of the rising-ramp value for the same phase.
- R7: Select code 3 (square). The output is +32767 while p[31]=0 and −32767 while p[31]=1.
- R8: Select code 4 (PWM). Let s be the R4 sine of the LFO phase, and let thr = 32768 + floor(s·13107 / 16384), which lies within 6554..58981. The output is +32767 while p[31:16] < thr and −32767 otherwise, so the duty cycle stays within 10%–90%.
- R9: Select codes 5, 6 and 7 give an output of 0.
- R10: The select is sampled only at a strobe. A select change between strobes has no effect on `wave_out` until the next strobe's sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_tick | input | 1 | One-cycle sample strobe that advances both phases |
| tune_main | input | 32 | Main oscillator phase increment per sample |
| tune_lfo | input | 32 | Pulse-width LFO phase increment per sample |
| wave_sel | input | 3 | Shape select: 0 sine, 1 rising ramp, 2 falling ramp, 3 square, 4 PWM, others silent |
| wave_out | output | 16 | Signed output sample |
| wave_vld | output | 1 | One-cycle pulse marking a new `wave_out` |

## Verification
A processor update of a tuning word or of the select can land in the very cycle that the sample strobe is high. The bench therefore changes `tune_main`, `tune_lfo` and `wave_sel` in the strobe cycle itself, and also between strobes. It judges the result against a running phase model in the bench, which applies the word present at the strobe and carries the phase on without a reset. In the PWM sweep, the LFO threshold and the main phase both move on every strobe. Each sample is then compared with the threshold computed from the same strobe's two phases.

// File: rtl/osc_pkg.sv
// Shared definitions for the multi-waveform oscillator.
// Assumes: quarter-wave table sized as a power of two; amplitude fits 31 bits.
package osc_pkg;

    // Output shape codes decoded by the shaper
    typedef enum logic [2:0] {
        SHP_SINE    = 3'd0,
        SHP_RAMP_UP = 3'd1,
        SHP_RAMP_DN = 3'd2,
        SHP_SQUARE  = 3'd3,
        SHP_PWM     = 3'd4
    } shape_e;

    // Rational sine approximation sampled at the centre of quarter-wave slot idx.
    // Half-offset sampling makes the folded table exactly symmetric.
    function automatic longint unsigned quarter_sine(input int unsigned idx,
                                                     input int unsigned qn,
                                                     input int unsigned amp);
        longint unsigned a, d, num, den;
        a   = 64'(2 * idx + 1);
        d   = 64'(4 * qn);
        num = 64'(amp) * 16 * a * (d - a);
        den = 5 * d * d - 4 * a * (d - a);
        return num / den;
    endfunction

endpackage

// File: rtl/osc_phase_acc.sv
// Phase accumulator: adds the increment on each step enable, wrapping modulo
// 2^PHASE_W. Exposes only the top HI_W bits that downstream logic needs.
// Assumes: step_en is a single-cycle strobe; increment is held by the caller.
module osc_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int HI_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic [PHASE_W-1:0] incr,
    output logic [HI_W-1:0]    phase_hi
);

    logic [PHASE_W-1:0] phase_q;

    // Advance the phase on each sample strobe; never cleared except by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (step_en) begin
            phase_q <= phase_q + incr;
        end
    end

    assign phase_hi = phase_q[PHASE_W-1 -: HI_W];

endmodule

// File: rtl/osc_sine_lut.sv
// Sine lookup: a quarter-wave magnitude table folded into a full period by
// the two quadrant bits. Combinational; one table per instance.
// Assumes: phase_hi holds the two quadrant bits above LUT_AW index bits.
module osc_sine_lut #(
    parameter int LUT_AW = 10,
    parameter int OUT_W  = 16
) (
    input  logic [LUT_AW+1:0]       phase_hi,
    output logic signed [OUT_W-1:0] sine
);

    localparam int QN  = 1 << LUT_AW;
    localparam int AMP = (1 << (OUT_W - 1)) - 1;

    logic [OUT_W-2:0]  rom [QN];
    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx;
    logic [LUT_AW-1:0] addr;
    logic [OUT_W-2:0]  mag;

    // Table contents computed from the package approximation
    for (genvar g = 0; g < QN; g++) begin : g_rom
        assign rom[g] = (OUT_W-1)'(osc_pkg::quarter_sine(g, QN, AMP));
    end

    assign quad = phase_hi[LUT_AW+1 -: 2];
    assign idx  = phase_hi[LUT_AW-1:0];

    // Fold the index in odd quadrants and negate in the second half-period
    always_comb begin
        addr = quad[0] ? ~idx : idx;
        mag  = rom[addr];
        sine = quad[1] ? (OUT_W'(0) - {1'b0, mag}) : {1'b0, mag};
    end

endmodule

// File: rtl/osc_shaper.sv
// Waveform shaper and output multiplexer: ramps, square and PWM comparator
// derived from the main phase; sine passed through from the lookup.
// Assumes: ph_hi is the top OUT_W bits of the main phase; sine_lfo is the
// signed LFO sine; DUTY_NUM/2^DUTY_SHIFT scales the threshold swing.
module osc_shaper #(
    parameter int OUT_W      = 16,
    parameter int DUTY_NUM   = 13107,
    parameter int DUTY_SHIFT = 14
) (
    input  logic [OUT_W-1:0]        ph_hi,
    input  logic signed [OUT_W-1:0] sine_main,
    input  logic signed [OUT_W-1:0] sine_lfo,
    input  logic [2:0]              sel,
    output logic signed [OUT_W-1:0] level
);

    import osc_pkg::*;

    localparam int PW   = OUT_W + 16;
    localparam int HALF = 1 << (OUT_W - 1);
    localparam logic [OUT_W-1:0] POS_FS = OUT_W'(HALF - 1);
    localparam logic [OUT_W-1:0] NEG_FS = OUT_W'(0) - POS_FS;

    logic [OUT_W-1:0]      ramp;
    logic signed [PW-1:0]  lfo_ext;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  offs;
    logic [OUT_W:0]        thr;
    logic                  pwm_hi;

    // Rising ramp: flip the MSB to centre the unsigned phase on zero
    assign ramp = {~ph_hi[OUT_W-1], ph_hi[OUT_W-2:0]};

    // PWM threshold: mid-scale plus the scaled LFO sine
    always_comb begin
        lfo_ext = PW'(sine_lfo);
        prod    = lfo_ext * $signed(PW'(DUTY_NUM));
        offs    = prod >>> DUTY_SHIFT;
        thr     = (OUT_W+1)'(HALF) + (OUT_W+1)'(offs);
        pwm_hi  = {1'b0, ph_hi} < thr;
    end

    // Output multiplexer over the shape codes
    always_comb begin
        case (sel)
            SHP_SINE:    level = sine_main;
            SHP_RAMP_UP: level = ramp;
            SHP_RAMP_DN: level = ~ramp;
            SHP_SQUARE:  level = ph_hi[OUT_W-1] ? NEG_FS : POS_FS;
            SHP_PWM:     level = pwm_hi ? POS_FS : NEG_FS;
            default:     level = '0;
        endcase
    end

endmodule

// File: rtl/wavesynth_osc.sv
// Top of the multi-waveform oscillator: two phase accumulators stepped by the
// sample strobe, two sine lookups, the shaper and a registered output with a
// valid pulse two clocks after the strobe.
// Assumes: smp_tick pulses for one cycle per sample; tuning and select inputs
// are held by a processor-side register and sampled at the strobe.
module wavesynth_osc #(
    parameter int PHASE_W    = 32,
    parameter int OUT_W      = 16,
    parameter int LUT_AW     = 10,
    parameter int DUTY_NUM   = 13107,
    parameter int DUTY_SHIFT = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_tick,
    input  logic [PHASE_W-1:0] tune_main,
    input  logic [PHASE_W-1:0] tune_lfo,
    input  logic [2:0]         wave_sel,
    output logic [OUT_W-1:0]   wave_out,
    output logic               wave_vld
);

    localparam int LUT_IN_W = LUT_AW + 2;

    logic [OUT_W-1:0]        ph_main_hi;
    logic [LUT_IN_W-1:0]     ph_lfo_hi;
    logic signed [OUT_W-1:0] sine_main;
    logic signed [OUT_W-1:0] sine_lfo;
    logic signed [OUT_W-1:0] level;
    logic [2:0]              sel_q;
    logic                    tick_d;

    osc_phase_acc #(.PHASE_W(PHASE_W), .HI_W(OUT_W)) u_acc_main (
        .clk(clk), .rst_n(rst_n), .step_en(smp_tick),
        .incr(tune_main), .phase_hi(ph_main_hi)
    );

    osc_phase_acc #(.PHASE_W(PHASE_W), .HI_W(LUT_IN_W)) u_acc_lfo (
        .clk(clk), .rst_n(rst_n), .step_en(smp_tick),
        .incr(tune_lfo), .phase_hi(ph_lfo_hi)
    );

    osc_sine_lut #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_lut_main (
        .phase_hi(ph_main_hi[OUT_W-1 -: LUT_IN_W]), .sine(sine_main)
    );

    osc_sine_lut #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_lut_lfo (
        .phase_hi(ph_lfo_hi), .sine(sine_lfo)
    );

    osc_shaper #(.OUT_W(OUT_W), .DUTY_NUM(DUTY_NUM), .DUTY_SHIFT(DUTY_SHIFT)) u_shaper (
        .ph_hi(ph_main_hi), .sine_main(sine_main), .sine_lfo(sine_lfo),
        .sel(sel_q), .level(level)
    );

    // Capture the shape select alongside the phase step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (smp_tick) begin
            sel_q <= wave_sel;
        end
    end

    // Delay the strobe by one cycle to register the new sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_d <= 1'b0;
        end else begin
            tick_d <= smp_tick;
        end
    end

    // Register the shaped sample and flag it valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_out <= '0;
            wave_vld <= 1'b0;
        end else begin
            wave_vld <= tick_d;
            if (tick_d) begin
                wave_out <= level;
            end
        end
    end

endmodule

// File: rtl/osc_chk.sv
// Assertion checker for wavesynth_osc, attached by bind below.
// Assumes: the bound phase view is the top OUT_W bits of the main phase.
module osc_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_tick,
    input logic [2:0]       wave_sel,
    input logic [OUT_W-1:0] wave_out,
    input logic             wave_vld,
    input logic [OUT_W-1:0] ph_hi
);

    localparam logic [OUT_W-1:0] POS_FS = OUT_W'((1 << (OUT_W - 1)) - 1);
    localparam logic [OUT_W-1:0] NEG_FS = OUT_W'(0) - POS_FS;

    AST_VLD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |-> ##2 wave_vld);                                            // R3
    AST_VLD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wave_vld |-> $past(smp_tick, 2));                                      // R3
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_vld |-> $stable(wave_out));                                      // R3
    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_tick) |-> $stable(ph_hi));                                  // R2
    AST_SQUARE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_vld && $past(wave_sel, 2) == 3'd3) |-> (wave_out == POS_FS || wave_out == NEG_FS)); // R7
    AST_PWM_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_vld && $past(wave_sel, 2) == 3'd4) |-> (wave_out == POS_FS || wave_out == NEG_FS)); // R8
    AST_SEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_vld && $past(wave_sel, 2) >= 3'd5) |-> (wave_out == '0));       // R9

endmodule

bind wavesynth_osc osc_chk #(.OUT_W(OUT_W)) u_osc_chk (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .wave_sel(wave_sel),
    .wave_out(wave_out), .wave_vld(wave_vld), .ph_hi(ph_main_hi)
);

// File: tb/test_wavesynth_osc.sv
// Self-checking bench: near-exhaustive phase sweeps per shape against a
// bench-side phase model and arithmetic expected values.
module test_wavesynth_osc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_tick = 1'b0;
    logic [31:0] tune_main = '0;
    logic [31:0] tune_lfo = '0;
    logic [2:0]  wave_sel = '0;
    logic [15:0] wave_out;
    logic        wave_vld;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] pm = '0;
    logic [31:0] pl = '0;
    logic [2:0]  sel_m = '0;

    always #4 clk = ~clk;

    wavesynth_osc i_wavesynth_osc (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .tune_main(tune_main),
        .tune_lfo(tune_lfo), .wave_sel(wave_sel), .wave_out(wave_out), .wave_vld(wave_vld)
    );

    function automatic int exp_sine(input logic [31:0] p);
        int      i;
        longint  a, m;
        i = int'(p[29:20]);
        if (p[30]) i = 1023 - i;
        a = 2 * i + 1;
        m = (64'd32767 * 16 * a * (4096 - a)) / (5 * 4096 * 4096 - 4 * a * (4096 - a));
        return p[31] ? -int'(m) : int'(m);
    endfunction

    function automatic int exp_wave(input logic [2:0] s, input logic [31:0] p, input logic [31:0] q);
        int up, lf, thr;
        up = int'(p[31:16]) - 32768;
        case (s)
            3'd0: return exp_sine(p);
            3'd1: return up;
            3'd2: return -up - 1;
            3'd3: return p[31] ? -32767 : 32767;
            3'd4: begin
                lf  = exp_sine(q);
                thr = 32768 + ((lf * 13107) >>> 14);
                return (int'(p[31:16]) < thr) ? 32767 : -32767;
            end
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One sample: drive inputs in the strobe cycle, then check valid timing and value
    task automatic step(input string req, input logic [31:0] tm, input logic [31:0] tl, input logic [2:0] s);
        @(negedge clk);
        tune_main = tm; tune_lfo = tl; wave_sel = s; smp_tick = 1'b1;
        pm = pm + tm; pl = pl + tl; sel_m = s;
        @(negedge clk);
        smp_tick = 1'b0;
        check("R3 vld low one clock after strobe", int'(wave_vld), 0);
        @(negedge clk);
        check("R3 vld high two clocks after strobe", int'(wave_vld), 1);
        check(req, int'($signed(wave_out)), exp_wave(sel_m, pm, pl));
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int hold;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out in reset", int'(wave_out), 0);
        check("R1 vld in reset", int'(wave_vld), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 out after reset", int'(wave_out), 0);
        check("R1 vld after reset", int'(wave_vld), 0);

        // R4: sine over every table slot (one index step per sample)
        for (int k = 0; k < 4096; k++) step("R4 sine", 32'h0010_0000, 32'h0, 3'd0);
        // R5: rising ramp with an odd increment, several wraps
        for (int k = 0; k < 300; k++) step("R5 rising ramp", 32'h0123_4567, 32'h0, 3'd1);
        // R2: tuning change in the strobe cycle, phase carries on without reset
        for (int k = 0; k < 50; k++) step("R2 ramp after tune change", 32'h0876_5431, 32'h0, 3'd1);
        // R6: falling ramp with a near-wrap increment
        for (int k = 0; k < 300; k++) step("R6 falling ramp", 32'hFEDC_BA98, 32'h0, 3'd2);
        // R7: square
        for (int k = 0; k < 300; k++) step("R7 square", 32'h0765_4321, 32'h0, 3'd3);
        // R8: PWM with both phases moving every strobe
        for (int k = 0; k < 2048; k++) step("R8 pwm", 32'h0200_0000, 32'h0100_0000, 3'd4);
        for (int k = 0; k < 600; k++) step("R8 pwm slow lfo", 32'h0033_3333, 32'h0011_1111, 3'd4);
        // R9: silent codes
        for (int s = 5; s < 8; s++)
            for (int k = 0; k < 20; k++) step("R9 silent code", 32'h0123_4567, 32'h0, 3'(s));

        // R10 and R2: select and tuning changes between strobes have no effect yet
        step("R10 square before idle change", 32'h0400_0000, 32'h0, 3'd3);
        hold = int'($signed(wave_out));
        @(negedge clk);
        wave_sel = 3'd0; tune_main = 32'h4000_0000;
        repeat (5) @(negedge clk);
        check("R10 out holds after idle select change", int'($signed(wave_out)), hold);
        check("R3 vld stays low between strobes", int'(wave_vld), 0);
        step("R10 new select at next strobe", 32'h0400_0000, 32'h0, 3'd0);
        step("R2 no drift between strobes", 32'h0000_0000, 32'h0, 3'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule